// File: doc/BRIEF.md
# Host status byte FIFO

This block carries status bytes from a control microprocessor to a host. The microprocessor pushes up to twelve opaque bytes, such as a decode outcome or a drive condition. It then signals that the status message is complete. From that point an active-low presence flag tells the host that status is waiting. The host pulls the bytes one at a time with a read strobe. The flag returns high on the read that removes the final stored byte.

The block never looks inside the bytes. Two further bits are visible to the microprocessor:

- a busy bit that stays set while any byte is still stored;
- a sticky overflow bit that records a write refused because the queue was full.

A clear command from the microprocessor empties the queue and drops the presence flag.

Top module: `stat_fifo`

## Requirements
- R1: After reset, stat_en_no is 1, stat_busy_o is 0, ovf_o is 0, count_o is 0 and host_rdata_o is 0.
- R2: Bytes reach host_rdata_o unchanged and in the order the microprocessor wrote them.
- R3: A uc_done_i pulse with at least one byte stored drives stat_en_no to 0 one clock after the pulse. A uc_done_i pulse with the queue empty leaves stat_en_no at 1.
- R4: A host_rd_i pulse while stat_en_no is 0 places the oldest stored byte on host_rdata_o one clock later and lowers count_o by one.
- R5: stat_en_no returns to 1 in the clock after the host read that removes the last stored byte.
- R6: A host_rd_i pulse while stat_en_no is 1 puts 0 on host_rdata_o one clock later and leaves count_o and the stored bytes untouched.
- R7: A uc_wr_i pulse while 12 bytes are stored is dropped and sets ovf_o, which stays 1 until a clear.
- R8: A uc_clear_i pulse empties the queue, resets both pointers, and sets stat_en_no to 1 and ovf_o to 0 one clock later. The next byte written is then the next byte read.
- R9: count_o equals the number of stored bytes, and stat_busy_o is 1 exactly when that number is nonzero.
- R10: The queue accepts and returns exactly 12 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uc_wr_i | input | 1 | Microprocessor byte write strobe |
| uc_wdata_i | input | 8 | Status byte to store |
| uc_done_i | input | 1 | Status message complete, arms the flag |
| uc_clear_i | input | 1 | Empty the queue and drop the flag |
| host_rd_i | input | 1 | Host read strobe |
| host_rdata_o | output | 8 | Byte returned for the last host read |
| stat_en_no | output | 1 | Status pending to host, active low |
| stat_busy_o | output | 1 | Bytes still stored |
| ovf_o | output | 1 | A write was refused while full (sticky) |
| count_o | output | 4 | Number of stored bytes |

## Verification
The assertions assume that every strobe is a single-clock pulse sampled at the rising edge. They also assume that a clear is not issued in the same clock as a write or read whose effect is being checked. The bench drives each strobe for one full clock from the falling edge. It never overlaps a clear with other strobes. It issues uc_done_i only after the writes of a message have been clocked in.

// File: rtl/stat_fifo_pkg.sv
package stat_fifo_pkg;
  localparam int unsigned DEF_DEPTH = 12;
  localparam int unsigned DEF_WIDTH = 8;
endpackage

// File: rtl/stat_fifo_ptr.sv
module stat_fifo_ptr #(
  parameter int unsigned DEPTH = stat_fifo_pkg::DEF_DEPTH,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [PW-1:0] ptr_o
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (clr_i)  ptr_o <= '0;
    else if (adv_i)  ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + PW'(1);
  end

  assert_ptr_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o <= LAST);
endmodule

// File: rtl/stat_fifo_ctrl.sv
module stat_fifo_ctrl #(
  parameter int unsigned DEPTH = stat_fifo_pkg::DEF_DEPTH,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          done_i,
  input  logic          clr_i,
  input  logic          rd_i,
  output logic          push_o,
  output logic          pop_o,
  output logic          armed_o,
  output logic          ovf_o,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] ONE  = CW'(1);

  assign push_o = wr_i & (count_o != FULL) & ~clr_i;
  assign pop_o  = rd_i & armed_o & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      armed_o <= 1'b0;
      ovf_o   <= 1'b0;
    end else if (clr_i) begin
      count_o <= '0;
      armed_o <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      if (push_o && !pop_o)      count_o <= count_o + ONE;
      else if (pop_o && !push_o) count_o <= count_o - ONE;
      // final byte leaves: drop flag; empty queue cannot be armed
      if (pop_o && !push_o && count_o == ONE) armed_o <= 1'b0;
      else if (done_i && count_o != '0)       armed_o <= 1'b1;
      if (wr_i && count_o == FULL) ovf_o <= 1'b1;
    end
  end

  assert_count_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= FULL);
  assert_armed_nonempty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o |-> count_o != '0);
  assert_last_read_drops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && armed_o && !wr_i && !clr_i && count_o == ONE) |=> !armed_o);
  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i && count_o == FULL) |=> (ovf_o && count_o <= FULL));
  assert_idle_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !armed_o && !wr_i && !clr_i) |=> $stable(count_o));
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_o == '0 && !armed_o && !ovf_o));
endmodule

// File: rtl/stat_fifo_mem.sv
module stat_fifo_mem #(
  parameter int unsigned DEPTH = stat_fifo_pkg::DEF_DEPTH,
  parameter int unsigned WIDTH = stat_fifo_pkg::DEF_WIDTH,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [PW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [PW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/stat_fifo.sv
module stat_fifo #(
  parameter int unsigned DEPTH = stat_fifo_pkg::DEF_DEPTH,
  parameter int unsigned WIDTH = stat_fifo_pkg::DEF_WIDTH,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             uc_wr_i,
  input  logic [WIDTH-1:0] uc_wdata_i,
  input  logic             uc_done_i,
  input  logic             uc_clear_i,
  input  logic             host_rd_i,
  output logic [WIDTH-1:0] host_rdata_o,
  output logic             stat_en_no,
  output logic             stat_busy_o,
  output logic             ovf_o,
  output logic [CW-1:0]    count_o
);
  logic          push, pop, armed;
  logic [PW-1:0] ptr [2];
  logic [WIDTH-1:0] head;

  stat_fifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk_i, .rst_ni,
    .wr_i(uc_wr_i), .done_i(uc_done_i), .clr_i(uc_clear_i), .rd_i(host_rd_i),
    .push_o(push), .pop_o(pop), .armed_o(armed), .ovf_o, .count_o
  );

  // index 0: write side, index 1: read side
  for (genvar g = 0; g < 2; g++) begin : g_ptr
    stat_fifo_ptr #(.DEPTH(DEPTH)) i_ptr (
      .clk_i, .rst_ni, .clr_i(uc_clear_i),
      .adv_i(g == 0 ? push : pop), .ptr_o(ptr[g])
    );
  end

  stat_fifo_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_mem (
    .clk_i, .we_i(push), .waddr_i(ptr[0]), .wdata_i(uc_wdata_i),
    .raddr_i(ptr[1]), .rdata_o(head)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         host_rdata_o <= '0;
    else if (uc_clear_i) host_rdata_o <= '0;
    else if (host_rd_i)  host_rdata_o <= pop ? head : '0;
  end

  assign stat_en_no  = ~armed;
  assign stat_busy_o = (count_o != '0);

  assert_idle_read_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && stat_en_no && !uc_clear_i) |=> host_rdata_o == '0);
  assert_flag_low_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_en_no |-> stat_busy_o);
endmodule

// File: tb/test_stat_fifo.sv
`timescale 1ns/1ps
module test_stat_fifo;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 0, done = 0, clr = 0, rd = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic en_n, busy, ovf;
  logic [3:0] cnt;
  int n_chk = 0, n_bad = 0;

  localparam logic [7:0] VEC [12] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80,
                                      8'h3C, 8'hC3, 8'h7E, 8'h11, 8'hE7, 8'h42};

  always #2.5 clk = ~clk;

  stat_fifo i_stat_fifo (
    .clk_i(clk), .rst_ni(rst_n), .uc_wr_i(wr), .uc_wdata_i(wdata),
    .uc_done_i(done), .uc_clear_i(clr), .host_rd_i(rd),
    .host_rdata_o(rdata), .stat_en_no(en_n), .stat_busy_o(busy),
    .ovf_o(ovf), .count_o(cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] b);
    @(negedge clk); wr = 1; wdata = b;
    @(negedge clk); wr = 0;
  endtask
  task automatic do_rd();
    @(negedge clk); rd = 1;
    @(negedge clk); rd = 0;
  endtask
  task automatic do_done();
    @(negedge clk); done = 1;
    @(negedge clk); done = 0;
  endtask
  task automatic do_clr();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  initial begin
    #50000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #12 rst_n = 1;
    @(negedge clk);
    chk("R1 en_n", en_n, 1); chk("R1 busy", busy, 0); chk("R1 ovf", ovf, 0);
    chk("R1 count", cnt, 0); chk("R1 rdata", rdata, 0);

    do_done();
    chk("R3 done on empty", en_n, 1);

    for (int i = 0; i < 12; i++) do_wr(VEC[i]);
    chk("R10 count full", cnt, 12); chk("R9 busy", busy, 1);
    chk("R3 not armed yet", en_n, 1);

    do_wr(8'h99);
    chk("R7 ovf set", ovf, 1); chk("R7 count held", cnt, 12);

    do_rd();
    chk("R6 idle read zero", rdata, 0); chk("R6 count held", cnt, 12);

    do_done();
    chk("R3 armed", en_n, 0);

    for (int i = 0; i < 12; i++) begin
      do_rd();
      chk("R2 R4 byte", rdata, VEC[i]);
      chk("R4 count", cnt, 11 - i);
      if (i < 11) chk("R5 flag held", en_n, 0);
    end
    chk("R5 flag up after last", en_n, 1); chk("R9 busy clear", busy, 0);
    chk("R7 ovf sticky", ovf, 1);

    do_rd();
    chk("R6 read after drain", rdata, 0); chk("R6 count zero", cnt, 0);

    do_wr(8'h21); do_wr(8'h22); do_wr(8'h23); do_done();
    do_rd();
    chk("R4 partial read", rdata, 8'h21);
    do_clr();
    chk("R8 en_n", en_n, 1); chk("R8 count", cnt, 0); chk("R8 ovf", ovf, 0);
    chk("R8 busy", busy, 0);

    do_wr(8'h5A); do_done();
    chk("R3 single byte armed", en_n, 0);
    do_rd();
    chk("R8 byte after clear", rdata, 8'h5A);
    chk("R5 single byte flag", en_n, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule